// File: doc/BRIEF.md
# Paged memory map decoder

This block is the combinational address decoder on the external bus of an 8051-style controller. Code fetches and data accesses share one 64K address space. The space is cut into eight 8K pages, and the page is selected by the three top address bits. An 8-bit page-control port assigns one bit to each page, and that bit chooses which physical memory backs the page. The block drives the chip selects for a flash device, a 128K SRAM and an I/O region. It also drives the shared output and write enables. The SRAM's top address line (A16) does not come from the processor, so the decoder drives it.

Bit n of the control port governs page n; the pages run from the bottom of the address space upward. For the middle pages, a set bit maps the page into the lower SRAM half. A clear bit maps it into the matching page of the upper half.

Page 0 is different. With its bit set, code fetches read the flash and data accesses reach an SRAM shadow of the flash. With its bit clear, all accesses to page 0 go to SRAM.

The top page is also different. With its bit clear, only its lower 4K goes to the upper SRAM half, and its upper 4K becomes the I/O window.

Top module: `pgdec_top`

## Requirements
- R1: While none of the program, read or write strobes is low, every chip select and both enables are high, and A16 is 0.
- R2: A code fetch (progN low) in page 0 (addrHi[3:1] = 0) with pageCtl[0] = 1 asserts flashCsN low and leaves sramCsN and ioCsN high, with A16 = 0. A code fetch takes precedence over a read or write that is low at the same time.
- R3: A data read or write in page 0 (rdN or wrN low, progN high) with pageCtl[0] = 1 selects SRAM with A16 = 0.
- R4: With pageCtl[0] = 0, every access to page 0 selects SRAM with A16 = 0.
- R5: Every access to pages 1 to 6 selects SRAM. A16 is the inverse of pageCtl[page], so a set bit means the lower half (A16 = 0) and a clear bit means the upper half (A16 = 1).
- R6: Every access to page 7 with pageCtl[7] = 1 selects SRAM with A16 = 0. With pageCtl[7] = 0, an access to the lower 4K of page 7 (addrHi[0] = 0) selects SRAM with A16 = 1.
- R7: With pageCtl[7] = 0, an access to the upper 4K of page 7 (addrHi[0] = 1) selects I/O (ioCsN low) with A16 = 0.
- R8: oeN is low exactly when rdN or progN is low.
- R9: weN is low exactly when wrN is low and flash is not selected.
- R10: While any strobe is low, exactly one of flashCsN, sramCsN and ioCsN is low.
- R11: The control bits of the pages that are not being addressed have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addrHi | input | 4 | Address bits A15..A12; the top three bits select the page and the lowest bit selects the half of the page |
| pageCtl | input | 8 | Page-control port, one bit per page |
| progN | input | 1 | Code-fetch strobe, active low |
| rdN | input | 1 | Data read strobe, active low |
| wrN | input | 1 | Data write strobe, active low |
| flashCsN | output | 1 | Flash chip select, active low |
| sramCsN | output | 1 | SRAM chip select, active low |
| ioCsN | output | 1 | I/O region select, active low |
| oeN | output | 1 | Shared output enable, active low |
| weN | output | 1 | Shared write enable, active low |
| sramA16 | output | 1 | Locally generated SRAM address bit 16 |

## Verification
The block holds no state, so the only possible fault is a wrong decode. A wrong decode shows on the selects or on A16 during the same access, with no delay. The bench applies every combination of address nibble, control byte and strobe pattern. Each combination is compared against a behavioural model that reads only the controlling bit of the addressed page. A bit that leaks in from another page, a half-page split on the wrong page, or a write that reaches the flash would each break the model on its first such vector.

// File: rtl/pgdec_pkg.sv
package pgdec_pkg;
  localparam int PAGE_BITS  = 3;
  localparam int NUM_PAGES  = 1 << PAGE_BITS;
  localparam int ADDR_W     = PAGE_BITS + 1;

  typedef struct packed {
    logic active;
    logic fetch;
    logic read;
    logic write;
  } dec_strobe_t;
endpackage

// File: rtl/pgdec_ctrl.sv
module pgdec_ctrl
  import pgdec_pkg::*;
(
  input  logic        progN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        flashSel,
  output dec_strobe_t stb,
  output logic        oeOut,
  output logic        weOut
);
  always_comb begin
    stb.fetch  = ~progN;
    stb.read   = ~rdN;
    stb.write  = ~wrN;
    stb.active = ~progN | ~rdN | ~wrN;
  end

  always_comb begin
    oeOut = stb.read | stb.fetch;
    weOut = stb.write & ~flashSel;
  end

  always_comb begin
    if (weOut) begin
      assert_we_mask_R9: assert (!wrN && !flashSel)
        else $error("write enable without write strobe or with flash selected");
    end
    if (oeOut) begin
      assert_oe_src_R8: assert (!rdN || !progN)
        else $error("output enable without read or program strobe");
    end
  end
endmodule

// File: rtl/pgdec_path.sv
module pgdec_path
  import pgdec_pkg::*;
(
  input  logic [ADDR_W-1:0]    pageAddr,
  input  logic [NUM_PAGES-1:0] pageCtl,
  input  dec_strobe_t          stb,
  output logic                 flashSel,
  output logic                 sramSel,
  output logic                 ioSel,
  output logic                 a16
);
  localparam int LAST = NUM_PAGES - 1;

  logic [PAGE_BITS-1:0] pageIdx;
  logic                 upperHalf;
  logic [NUM_PAGES-1:0] flashV, sramV, ioV, hiV, hitV;

  assign pageIdx   = pageAddr[ADDR_W-1:1];
  assign upperHalf = pageAddr[0];

  for (genvar n = 0; n < NUM_PAGES; n++) begin : g_page
    assign hitV[n] = (pageIdx == PAGE_BITS'(n)) & stb.active;
    if (n == 0) begin : g_boot
      assign flashV[n] = hitV[n] & pageCtl[n] & stb.fetch;
      assign sramV[n]  = hitV[n] & ~(pageCtl[n] & stb.fetch);
      assign ioV[n]    = 1'b0;
      assign hiV[n]    = 1'b0;
    end else if (n == LAST) begin : g_top
      assign flashV[n] = 1'b0;
      assign ioV[n]    = hitV[n] & ~pageCtl[n] & upperHalf;
      assign sramV[n]  = hitV[n] & (pageCtl[n] | ~upperHalf);
      assign hiV[n]    = hitV[n] & ~pageCtl[n] & ~upperHalf;
    end else begin : g_mid
      assign flashV[n] = 1'b0;
      assign ioV[n]    = 1'b0;
      assign sramV[n]  = hitV[n];
      assign hiV[n]    = hitV[n] & ~pageCtl[n];
    end
  end

  assign flashSel = |flashV;
  assign sramSel  = |sramV;
  assign ioSel    = |ioV;
  assign a16      = |hiV;

  always_comb begin
    assert_strobe_sum_R1: assert (stb.active == (stb.fetch | stb.read | stb.write))
      else $error("strobe summary inconsistent");
    if (!stb.active) begin
      assert_idle_R1: assert (!flashSel && !sramSel && !ioSel && !a16)
        else $error("select active while bus idle");
    end else begin
      assert_onehot_sel_R10: assert ($countones({flashSel, sramSel, ioSel}) == 1)
        else $error("not exactly one device selected");
    end
    if (flashSel) begin
      assert_flash_boot_R2: assert (pageIdx == '0 && stb.fetch && pageCtl[0] && !a16)
        else $error("flash selected outside boot code fetch");
    end
    if (ioSel) begin
      assert_io_window_R7: assert (pageIdx == PAGE_BITS'(LAST) && upperHalf && !a16)
        else $error("io selected outside top window");
    end
    if (stb.active && !stb.fetch && pageIdx == '0) begin
      assert_data_shadow_R3: assert (sramSel && !a16)
        else $error("boot page data access not on sram");
    end
  end
endmodule

// File: rtl/pgdec_top.sv
module pgdec_top
  import pgdec_pkg::*;
(
  input  logic [ADDR_W-1:0]    addrHi,
  input  logic [NUM_PAGES-1:0] pageCtl,
  input  logic                 progN,
  input  logic                 rdN,
  input  logic                 wrN,
  output logic                 flashCsN,
  output logic                 sramCsN,
  output logic                 ioCsN,
  output logic                 oeN,
  output logic                 weN,
  output logic                 sramA16
);
  dec_strobe_t stb;
  logic flashSel, sramSel, ioSel, a16, oeOut, weOut;

  pgdec_ctrl u_ctrl (
    .progN    (progN),
    .rdN      (rdN),
    .wrN      (wrN),
    .flashSel (flashSel),
    .stb      (stb),
    .oeOut    (oeOut),
    .weOut    (weOut)
  );

  pgdec_path u_path (
    .pageAddr (addrHi),
    .pageCtl  (pageCtl),
    .stb      (stb),
    .flashSel (flashSel),
    .sramSel  (sramSel),
    .ioSel    (ioSel),
    .a16      (a16)
  );

  assign flashCsN = ~flashSel;
  assign sramCsN  = ~sramSel;
  assign ioCsN    = ~ioSel;
  assign oeN      = ~oeOut;
  assign weN      = ~weOut;
  assign sramA16  = a16;
endmodule

// File: tb/test_pgdec_top.sv
module test_pgdec_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0] addrHi;
  logic [7:0] pageCtl;
  logic progN, rdN, wrN;
  logic flashCsN, sramCsN, ioCsN, oeN, weN, sramA16;

  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  pgdec_top i_pgdec_top (
    .addrHi(addrHi), .pageCtl(pageCtl), .progN(progN), .rdN(rdN), .wrN(wrN),
    .flashCsN(flashCsN), .sramCsN(sramCsN), .ioCsN(ioCsN),
    .oeN(oeN), .weN(weN), .sramA16(sramA16)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (addr=%h ctl=%h p=%b r=%b w=%b)",
               req, what, act, exp, addrHi, pageCtl, progN, rdN, wrN);
    end
  endtask

  task automatic checkNow();
    int addr, page, fl, sr, io, hi, oe, we;
    bit isFetch, any, ctl;
    string req;
    addr = int'(addrHi) * 4096;
    page = addr / 8192;
    ctl = pageCtl[page];
    isFetch = !progN;
    any = !progN || !rdN || !wrN;
    fl = 0; sr = 0; io = 0; hi = 0;
    if (!any) req = "R1";
    else if (page == 0) begin
      if (!ctl) begin req = "R4"; sr = 1; end
      else if (isFetch) begin req = "R2"; fl = 1; end
      else begin req = "R3"; sr = 1; end
    end else if (page == 7) begin
      if (ctl) begin req = "R6"; sr = 1; end
      else if (addr >= 16'hF000) begin req = "R7"; io = 1; end
      else begin req = "R6"; sr = 1; hi = 1; end
    end else begin
      req = "R5"; sr = 1; hi = ctl ? 0 : 1;
    end
    oe = (!rdN || !progN) ? 1 : 0;
    we = (!wrN && fl == 0) ? 1 : 0;
    vectors++;
    // R11: the expected values depend only on the addressed page's bit
    cmp({req, "/R11"}, "flash", int'(!flashCsN), fl);
    cmp({req, "/R11"}, "sram", int'(!sramCsN), sr);
    cmp({req, "/R11"}, "io", int'(!ioCsN), io);
    cmp({req, "/R11"}, "a16", int'(sramA16), hi);
    cmp("R8", "oe", int'(!oeN), oe);
    cmp("R9", "we", int'(!weN), we);
    if (any) cmp("R10", "selcount", int'(!flashCsN) + int'(!sramCsN) + int'(!ioCsN), 1);
  endtask

  initial begin
    addrHi = '0; pageCtl = '0; progN = 1'b1; rdN = 1'b1; wrN = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkNow();  // R1 reset-time idle
    rst = 1'b0;
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 256; c++) begin
        for (int a = 0; a < 16; a++) begin
          @(posedge clk);
          addrHi = 4'(a); pageCtl = 8'(c);
          progN = s[0]; rdN = s[1]; wrN = s[2];
          @(negedge clk);
          checkNow();
        end
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (60000) @(posedge clk); end
    join_any
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule